// File: doc/BRIEF.md
# Expansion Board Identification Chain Responder

This block answers a CPU's probing of expansion boards in a fixed 64 KB configuration window. It holds two boards in a chain, and only the board at the head of the chain is visible. A byte read in the window returns one nibble of that board's identification descriptor in the upper half of the data byte. Some offsets come back inverted, as the probing software expects.

Byte writes to three command offsets act on the head board. One writes the low nibble of the board's base address. One writes the high nibble, marks the board configured and passes the head to the next board. One tells the board to stay unmapped and also passes the head on. After the last board has been passed, the block raises a done flag and stops answering in the window. System decode uses each board's base and configured flag to map the memory behind it, and that memory lies outside this block.

Reads are combinational in the cycle of the access. Writes take effect at the rising clock edge on which they are presented.

Top module: `expn_id_chain`

## Requirements
- R1: A synchronous active-low reset makes board 0 the head of the chain and clears every configured flag, every base address and the done flag.
- R2: A read at an even window offset 2n with n below 20 returns descriptor nibble n of the head board in data bits 7:4, and zero in bits 3:0 before the inversion of R4 is applied.
- R3: A read at an odd offset, or at an even offset of 0x28 or above, has a zero byte before the inversion, so it returns 0xF0 when R4 inverts it and 0x00 otherwise.
- R4: The read byte is XORed with 0xF0 at every offset except 0x00, 0x02, 0x40 and 0x42.
- R5: A write at offset 0x4A loads base bits 19:16 of the head board from data bits 7:4 and clears that board's other base bits. It does not move the head.
- R6: A write at offset 0x48 loads base bits 23:20 of the head board from data bits 7:4, keeps bits 19:16, sets that board's configured flag and moves the head to the next board.
- R7: A write at offset 0x4C moves the head to the next board and leaves that board's configured flag and base unchanged.
- R8: Moving past the last board sets the done flag. The done flag stays set until reset, and while it is set the window gives no hit, reads return 0x00 and writes have no effect.
- R9: Writes at any other window offset, writes outside the window and all reads leave the head, the bases and the flags unchanged.
- R10: The hit output is high exactly when an access is valid, address bits 23:16 equal the window base 0xE8 (window 0xE80000 to 0xE8FFFF) and the done flag is clear. When hit is low the read data is 0x00.
- R11: Board 0's descriptor nibbles 0 to 19 are E,0,6,9,8,0,0,0,0,7,D,B,0,0,0,0,0,4,2,0. Board 1's are C,1,A,3,0,0,0,0,0,7,D,B,A,3,1,4,0,0,0,0. Nibble 1 is the size code: 0=8 MB, 1=64 KB, 2=128 KB, 3=256 KB, 4=512 KB, 5=1 MB, 6=2 MB, 7=4 MB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A CPU byte access is presented this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 24 | Byte address of the access |
| acc_wdata_hi | input | 4 | Data bits 7:4 of a write; the lower nibble carries nothing for this block |
| acc_hit | output | 1 | The window claims this access |
| acc_rdata | output | 8 | Read byte (0x00 when not hit) |
| brd_base | output | 48 | Assigned base of each board, board b at bits 24b+23:24b |
| brd_cfg | output | 2 | Configured flag per board |
| chain_done | output | 1 | All boards passed; window removed |

## Verification
The hardest case to reach is the second board's descriptor and base handling. Board 1 is only visible after board 0 has left the chain, and it can leave by two routes. The stimulus covers both. In one pass board 0 is configured, and all 128 low offsets of board 1 are swept before it is shut up. After a fresh reset, board 0 is shut up and board 1 is given a base, so the done flag is reached along the second route as well. Writes after done are then checked for having no effect.

// File: rtl/expn_id_pkg.sv
// Package: shared command encoding and window offset constants for the
// expansion identification chain. Assumes a 64 KB window addressed by
// the low 16 address bits.
package expn_id_pkg;

    localparam int WIN_OFS_W = 16;

    // Command offsets inside the window
    localparam logic [WIN_OFS_W-1:0] OFS_BASE_LO = 16'h004A;
    localparam logic [WIN_OFS_W-1:0] OFS_BASE_HI = 16'h0048;
    localparam logic [WIN_OFS_W-1:0] OFS_SHUTUP  = 16'h004C;

    // Offsets whose read byte is returned without inversion
    localparam logic [WIN_OFS_W-1:0] OFS_PLAIN_A = 16'h0000;
    localparam logic [WIN_OFS_W-1:0] OFS_PLAIN_B = 16'h0002;
    localparam logic [WIN_OFS_W-1:0] OFS_PLAIN_C = 16'h0040;
    localparam logic [WIN_OFS_W-1:0] OFS_PLAIN_D = 16'h0042;

    localparam logic [7:0] INV_MASK = 8'hF0;

    typedef enum logic [1:0] {
        WR_NONE    = 2'd0,
        WR_BASE_LO = 2'd1,
        WR_BASE_HI = 2'd2,
        WR_SHUTUP  = 2'd3
    } wr_cmd_e;

    // True when a read at this offset is returned without inversion
    function automatic logic ofs_is_plain(input logic [WIN_OFS_W-1:0] ofs);
        return (ofs == OFS_PLAIN_A) || (ofs == OFS_PLAIN_B) ||
               (ofs == OFS_PLAIN_C) || (ofs == OFS_PLAIN_D);
    endfunction

endpackage

// File: rtl/expn_win_decode.sv
// Window decoder: claims accesses in the configuration window while the
// chain is active, splits the offset into a descriptor nibble index and
// classifies writes into chain commands. Assumes ADDR_W > WIN_OFS_W.
module expn_win_decode
    import expn_id_pkg::*;
#(
    parameter int              ADDR_W    = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE = 24'hE80000,
    parameter int              NIBBLES   = 20,
    parameter int              NIB_IDX_W = 5
) (
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic                 chain_done,
    output logic                 hit,
    output logic [WIN_OFS_W-1:0] ofs,
    output logic [NIB_IDX_W-1:0] nib_idx,
    output logic                 nib_in_range,
    output wr_cmd_e              wr_cmd
);

    localparam int PAGE_W = ADDR_W - WIN_OFS_W;
    localparam logic [PAGE_W-1:0] WIN_PAGE = WIN_BASE[ADDR_W-1:WIN_OFS_W];

    logic page_match;

    // Page compare and window claim
    always_comb begin
        page_match = (acc_addr[ADDR_W-1:WIN_OFS_W] == WIN_PAGE);
        hit        = acc_valid && page_match && !chain_done;
        ofs        = acc_addr[WIN_OFS_W-1:0];
    end

    // Descriptor nibble index: even offsets inside the table only
    always_comb begin
        nib_idx      = ofs[NIB_IDX_W:1];
        nib_in_range = !ofs[0] && (ofs[WIN_OFS_W-1:1] < (WIN_OFS_W-1)'(NIBBLES));
    end

    // Write command classification
    always_comb begin
        wr_cmd = WR_NONE;
        if (hit && acc_write) begin
            unique case (ofs)
                OFS_BASE_LO: wr_cmd = WR_BASE_LO;
                OFS_BASE_HI: wr_cmd = WR_BASE_HI;
                OFS_SHUTUP:  wr_cmd = WR_SHUTUP;
                default:     wr_cmd = WR_NONE;
            endcase
        end
    end

endmodule

// File: rtl/expn_desc_rom.sv
// Descriptor store: returns one nibble of the selected board's fixed
// identification descriptor. Board b's nibble n sits at bit 4*(b*NIBBLES+n)
// of DESC_TABLE. An index at or past NIBBLES returns zero.
module expn_desc_rom #(
    parameter int NUM_BOARDS = 2,
    parameter int NIBBLES    = 20,
    parameter int BIDX_W     = 1,
    parameter int NIB_IDX_W  = 5,
    parameter logic [NUM_BOARDS*NIBBLES*4-1:0] DESC_TABLE = '0
) (
    input  logic [BIDX_W-1:0]    brd_sel,
    input  logic [NIB_IDX_W-1:0] nib_idx,
    output logic [3:0]           nib
);

    localparam int ROW_W = NIBBLES * 4;

    logic [ROW_W-1:0] rows [NUM_BOARDS];
    logic [ROW_W-1:0] sel_row;

    // One descriptor row per board
    for (genvar b = 0; b < NUM_BOARDS; b++) begin : g_row
        assign rows[b] = DESC_TABLE[b*ROW_W +: ROW_W];
    end

    // Row select by head board
    always_comb begin
        sel_row = '0;
        for (int b = 0; b < NUM_BOARDS; b++) begin
            if (brd_sel == BIDX_W'(b)) sel_row = rows[b];
        end
    end

    // Nibble select within the row
    always_comb begin
        nib = 4'h0;
        for (int n = 0; n < NIBBLES; n++) begin
            if (nib_idx == NIB_IDX_W'(n)) nib = sel_row[n*4 +: 4];
        end
    end

endmodule

// File: rtl/expn_rd_format.sv
// Read formatter: places the descriptor nibble in the upper half of the
// byte, zeroes bytes outside the table and applies the upper-nibble
// inversion everywhere except the plain offsets. Drives zero when not hit.
module expn_rd_format
    import expn_id_pkg::*;
(
    input  logic                 hit,
    input  logic [WIN_OFS_W-1:0] ofs,
    input  logic                 nib_in_range,
    input  logic [3:0]           nib,
    output logic [7:0]           rdata
);

    logic [7:0] raw;

    // Raw byte before inversion
    always_comb begin
        raw = nib_in_range ? {nib, 4'h0} : 8'h00;
    end

    // Inversion and output gating
    always_comb begin
        if (!hit)                 rdata = 8'h00;
        else if (ofs_is_plain(ofs)) rdata = raw;
        else                      rdata = raw ^ INV_MASK;
    end

endmodule

// File: rtl/expn_chain_ctrl.sv
// Chain controller: tracks the head board, each board's base nibbles and
// configured flag, and the done flag. Assumes commands arrive already
// gated by the window claim. Bases are 24-bit with the low 16 bits zero.
module expn_chain_ctrl
    import expn_id_pkg::*;
#(
    parameter int NUM_BOARDS = 2,
    parameter int BIDX_W     = 1,
    parameter int ADDR_W     = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  wr_cmd_e                      wr_cmd,
    input  logic [3:0]                   wr_nib,
    output logic [BIDX_W-1:0]            cur_brd,
    output logic [NUM_BOARDS*ADDR_W-1:0] brd_base,
    output logic [NUM_BOARDS-1:0]        brd_cfg,
    output logic                         chain_done
);

    localparam logic [BIDX_W-1:0] LAST_BRD = BIDX_W'(NUM_BOARDS - 1);

    logic advance;

    // A base-high or shut-up command passes the head on
    always_comb begin
        advance = !chain_done && ((wr_cmd == WR_BASE_HI) || (wr_cmd == WR_SHUTUP));
    end

    // Head pointer and done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_brd    <= '0;
            chain_done <= 1'b0;
        end else if (advance) begin
            if (cur_brd == LAST_BRD) chain_done <= 1'b1;
            else                     cur_brd    <= cur_brd + 1'b1;
        end
    end

    // Per-board base nibbles and configured flag
    for (genvar b = 0; b < NUM_BOARDS; b++) begin : g_brd
        logic [7:0] page_q;
        logic       cfg_q;
        logic       is_head;

        assign is_head = (cur_brd == BIDX_W'(b)) && !chain_done;

        // Apply base and configure commands aimed at this board
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                page_q <= 8'h00;
                cfg_q  <= 1'b0;
            end else if (is_head) begin
                case (wr_cmd)
                    WR_BASE_LO: page_q <= {4'h0, wr_nib};
                    WR_BASE_HI: begin
                        page_q[7:4] <= wr_nib;
                        cfg_q       <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        assign brd_base[b*ADDR_W +: ADDR_W] = ADDR_W'({page_q, 16'h0000});
        assign brd_cfg[b]                   = cfg_q;
    end

endmodule

// File: rtl/expn_id_chain.sv
// Top: expansion board identification chain responder. Presents the head
// board's descriptor in the configuration window, accepts base and
// shut-up writes, and reports bases, configured flags and completion.
// Assumes single-cycle byte accesses and ADDR_W of 24.
module expn_id_chain
    import expn_id_pkg::*;
#(
    parameter int                ADDR_W     = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 24'hE80000,
    parameter int                NUM_BOARDS = 2,
    parameter int                NIBBLES    = 20,
    parameter logic [NUM_BOARDS*NIBBLES*4-1:0] DESC_TABLE =
        {80'h0000413ABD7000003A1C, 80'h02400000BD700008960E}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         acc_valid,
    input  logic                         acc_write,
    input  logic [ADDR_W-1:0]            acc_addr,
    input  logic [3:0]                   acc_wdata_hi,
    output logic                         acc_hit,
    output logic [7:0]                   acc_rdata,
    output logic [NUM_BOARDS*ADDR_W-1:0] brd_base,
    output logic [NUM_BOARDS-1:0]        brd_cfg,
    output logic                         chain_done
);

    localparam int BIDX_W    = (NUM_BOARDS > 1) ? $clog2(NUM_BOARDS) : 1;
    localparam int NIB_IDX_W = (NIBBLES > 1) ? $clog2(NIBBLES) : 1;

    logic [WIN_OFS_W-1:0] ofs;
    logic [NIB_IDX_W-1:0] nib_idx;
    logic                 nib_in_range;
    wr_cmd_e              wr_cmd;
    logic [BIDX_W-1:0]    cur_brd;
    logic [3:0]           nib;

    expn_win_decode #(
        .ADDR_W    (ADDR_W),
        .WIN_BASE  (WIN_BASE),
        .NIBBLES   (NIBBLES),
        .NIB_IDX_W (NIB_IDX_W)
    ) u_dec (
        .acc_valid    (acc_valid),
        .acc_write    (acc_write),
        .acc_addr     (acc_addr),
        .chain_done   (chain_done),
        .hit          (acc_hit),
        .ofs          (ofs),
        .nib_idx      (nib_idx),
        .nib_in_range (nib_in_range),
        .wr_cmd       (wr_cmd)
    );

    expn_desc_rom #(
        .NUM_BOARDS (NUM_BOARDS),
        .NIBBLES    (NIBBLES),
        .BIDX_W     (BIDX_W),
        .NIB_IDX_W  (NIB_IDX_W),
        .DESC_TABLE (DESC_TABLE)
    ) u_rom (
        .brd_sel (cur_brd),
        .nib_idx (nib_idx),
        .nib     (nib)
    );

    expn_rd_format u_fmt (
        .hit          (acc_hit),
        .ofs          (ofs),
        .nib_in_range (nib_in_range),
        .nib          (nib),
        .rdata        (acc_rdata)
    );

    expn_chain_ctrl #(
        .NUM_BOARDS (NUM_BOARDS),
        .BIDX_W     (BIDX_W),
        .ADDR_W     (ADDR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cmd     (wr_cmd),
        .wr_nib     (acc_wdata_hi),
        .cur_brd    (cur_brd),
        .brd_base   (brd_base),
        .brd_cfg    (brd_cfg),
        .chain_done (chain_done)
    );

endmodule

// File: rtl/expn_id_chain_chk.sv
// Checker: port-level properties of the identification chain responder,
// bound to every instance of the top module.
module expn_id_chain_chk #(
    parameter int                ADDR_W     = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 24'hE80000,
    parameter int                NUM_BOARDS = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         acc_valid,
    input logic                         acc_write,
    input logic [ADDR_W-1:0]            acc_addr,
    input logic                         acc_hit,
    input logic [7:0]                   acc_rdata,
    input logic [NUM_BOARDS*ADDR_W-1:0] brd_base,
    input logic [NUM_BOARDS-1:0]        brd_cfg,
    input logic                         chain_done
);

    logic        in_win;
    logic [15:0] ofs;
    logic        wr_live;
    logic        wr_hi;
    logic        wr_base;
    logic        wr_adv;

    // Independent view of window writes
    always_comb begin
        in_win  = acc_valid && (acc_addr[ADDR_W-1:16] == WIN_BASE[ADDR_W-1:16]);
        ofs     = acc_addr[15:0];
        wr_live = in_win && acc_write && !chain_done;
        wr_hi   = wr_live && (ofs == 16'h0048);
        wr_base = wr_live && ((ofs == 16'h0048) || (ofs == 16'h004A));
        wr_adv  = wr_live && ((ofs == 16'h0048) || (ofs == 16'h004C));
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (brd_cfg == '0 && !chain_done && brd_base == '0));

    // R10
    hit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit == (in_win && !chain_done));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |=> chain_done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |-> (!acc_hit && acc_rdata == 8'h00));

    // R8
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_done) |-> $past(wr_adv));

    // R6
    cfg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brd_cfg != $past(brd_cfg)) |-> $past(wr_hi));

    // R9
    base_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brd_base != $past(brd_base)) |-> $past(wr_base));

    // R3
    odd_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hit && acc_addr[0]) |-> (acc_rdata == 8'hF0));

    // R2
    low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit |-> (acc_rdata[3:0] == 4'h0));

endmodule

bind expn_id_chain expn_id_chain_chk #(
    .ADDR_W     (ADDR_W),
    .WIN_BASE   (WIN_BASE),
    .NUM_BOARDS (NUM_BOARDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .acc_hit    (acc_hit),
    .acc_rdata  (acc_rdata),
    .brd_base   (brd_base),
    .brd_cfg    (brd_cfg),
    .chain_done (chain_done)
);

// File: tb/expn_id_chain_test.sv
module expn_id_chain_test;

    localparam logic [7:0] WIN_PG = 8'hE8;

    localparam logic [3:0] DESC0 [0:19] = '{4'hE,4'h0,4'h6,4'h9,4'h8,4'h0,4'h0,4'h0,4'h0,4'h7,
                                           4'hD,4'hB,4'h0,4'h0,4'h0,4'h0,4'h0,4'h4,4'h2,4'h0};
    localparam logic [3:0] DESC1 [0:19] = '{4'hC,4'h1,4'hA,4'h3,4'h0,4'h0,4'h0,4'h0,4'h0,4'h7,
                                           4'hD,4'hB,4'hA,4'h3,4'h1,4'h4,4'h0,4'h0,4'h0,4'h0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [23:0] acc_addr = '0;
    logic [3:0]  acc_wdata_hi = '0;
    logic        acc_hit;
    logic [7:0]  acc_rdata;
    logic [47:0] brd_base;
    logic [1:0]  brd_cfg;
    logic        chain_done;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    expn_id_chain uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_write    (acc_write),
        .acc_addr     (acc_addr),
        .acc_wdata_hi (acc_wdata_hi),
        .acc_hit      (acc_hit),
        .acc_rdata    (acc_rdata),
        .brd_base     (brd_base),
        .brd_cfg      (brd_cfg),
        .chain_done   (chain_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int brd, input int off);
        logic [3:0] nb;
        logic [7:0] b;
        nb = 4'h0;
        if ((off % 2 == 0) && (off / 2 < 20)) nb = (brd == 1) ? DESC1[off/2] : DESC0[off/2];
        b = {nb, 4'h0};
        if (!(off == 0 || off == 2 || off == 64 || off == 66)) b = b ^ 8'hF0;
        return b;
    endfunction

    function automatic string tag_of(input int off);
        if (off == 0 || off == 2 || off == 64 || off == 66) return "R4";
        if ((off % 2 == 1) || (off / 2 >= 20)) return "R3";
        return "R2";
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rd(input logic [23:0] addr, output logic [7:0] d, output logic h);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = 1'b0;
        acc_addr  = addr;
        #1;
        d = acc_rdata;
        h = acc_hit;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic wr(input logic [23:0] addr, input logic [3:0] dhi);
        @(negedge clk);
        acc_valid    = 1'b1;
        acc_write    = 1'b1;
        acc_addr     = addr;
        acc_wdata_hi = dhi;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
        #1;
    endtask

    task automatic sweep(input int brd, input bit is_r11);
        logic [7:0] d;
        logic h;
        for (int off = 0; off < 128; off++) begin
            rd({WIN_PG, 16'(off)}, d, h);
            chk(is_r11 ? "R11" : tag_of(off), {24'h0, d}, {24'h0, exp_byte(brd, off)});
            if (off % 32 == 0) chk("R10 hit", {31'h0, h}, 32'h1);
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic h;

        do_reset();
        #1;
        chk("R1 cfg", {30'h0, brd_cfg}, 32'h0);
        chk("R1 done", {31'h0, chain_done}, 32'h0);
        chk("R1 base", brd_base[31:0] | brd_base[47:24], 32'h0);

        // board 0 descriptor sweep
        sweep(0, 1'b0);
        rd({WIN_PG, 16'hFFFF}, d, h);
        chk("R3 top odd", {24'h0, d}, 32'hF0);
        rd({WIN_PG, 16'h8000}, d, h);
        chk("R3 far even", {24'h0, d}, 32'hF0);

        // ignored writes
        wr({WIN_PG, 16'h0050}, 4'hF);
        wr({WIN_PG, 16'h0049}, 4'hF);
        wr(24'hE90048, 4'h7);
        rd({WIN_PG, 16'h0000}, d, h);
        chk("R9 head unchanged", {24'h0, d}, 32'hE0);
        chk("R9 cfg", {30'h0, brd_cfg}, 32'h0);
        chk("R9 base", brd_base[31:0], 32'h0);
        rd(24'hE90000, d, h);
        chk("R10 outside hit", {31'h0, h}, 32'h0);
        chk("R10 outside data", {24'h0, d}, 32'h0);

        // base low then high on board 0
        wr({WIN_PG, 16'h004A}, 4'h2);
        chk("R5 base0", {8'h0, brd_base[23:0]}, 32'h020000);
        chk("R5 cfg", {30'h0, brd_cfg}, 32'h0);
        rd({WIN_PG, 16'h0000}, d, h);
        chk("R5 no advance", {24'h0, d}, 32'hE0);
        wr({WIN_PG, 16'h0048}, 4'hA);
        chk("R6 base0", {8'h0, brd_base[23:0]}, 32'hA20000);
        chk("R6 cfg", {30'h0, brd_cfg}, 32'h1);
        chk("R6 not done", {31'h0, chain_done}, 32'h0);

        // board 1 descriptor sweep
        sweep(1, 1'b1);

        // shut up board 1
        wr({WIN_PG, 16'h004C}, 4'h0);
        chk("R8 done", {31'h0, chain_done}, 32'h1);
        chk("R7 cfg", {30'h0, brd_cfg}, 32'h1);
        chk("R7 base1", {8'h0, brd_base[47:24]}, 32'h0);
        rd({WIN_PG, 16'h0000}, d, h);
        chk("R8 no hit", {31'h0, h}, 32'h0);
        chk("R8 data", {24'h0, d}, 32'h0);
        wr({WIN_PG, 16'h004A}, 4'h3);
        wr({WIN_PG, 16'h0048}, 4'h3);
        chk("R8 base1 kept", {8'h0, brd_base[47:24]}, 32'h0);
        chk("R8 base0 kept", {8'h0, brd_base[23:0]}, 32'hA20000);
        chk("R8 cfg kept", {30'h0, brd_cfg}, 32'h1);
        chk("R8 still done", {31'h0, chain_done}, 32'h1);

        // second route: shut up board 0, configure board 1
        do_reset();
        #1;
        chk("R1 cfg again", {30'h0, brd_cfg}, 32'h0);
        chk("R1 base again", {8'h0, brd_base[23:0]}, 32'h0);
        chk("R1 done again", {31'h0, chain_done}, 32'h0);
        wr({WIN_PG, 16'h004C}, 4'hF);
        chk("R7 cfg", {30'h0, brd_cfg}, 32'h0);
        chk("R7 base0", {8'h0, brd_base[23:0]}, 32'h0);
        rd({WIN_PG, 16'h0000}, d, h);
        chk("R7 head is board1", {24'h0, d}, 32'hC0);
        rd({WIN_PG, 16'h0002}, d, h);
        chk("R11 size code", {24'h0, d}, 32'h10);
        wr({WIN_PG, 16'h004A}, 4'h5);
        wr({WIN_PG, 16'h0048}, 4'h9);
        chk("R6 base1", {8'h0, brd_base[47:24]}, 32'h950000);
        chk("R6 cfg1", {30'h0, brd_cfg}, 32'h2);
        chk("R8 done route2", {31'h0, chain_done}, 32'h1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule